// File: doc/BRIEF.md
# Pipelined Fixed-Point Square Root

This block computes the square root of an unsigned 64-bit integer and returns it as an unsigned fixed-point value with 32 integer bits and 4 fraction bits. Eight zero bits are appended below the operand's least significant bit. The widened 72-bit value is then passed through a restoring, bit-serial integer square root. Because the input was scaled by 2^8, the integer root of the widened value is already the 32.4 result, and no correction step is needed.

The 36 root bits are produced most-significant first. The unrolled recurrence is divided into six registered stages, and each stage resolves six bits. A new operand can enter on every clock cycle. Each result appears a fixed number of cycles after its operand, with a valid flag beside it. There is no stall input, and the result is truncated, never rounded.

Top module: `sqrt_pipe`

## Requirements
- R1: `out_root` equals floor(sqrt(x·256)) for the operand x. Bits [35:4] hold the integer part and bits [3:0] hold sixteenths. Truncation is the only rounding.
- R2: `out_valid` is high exactly 6 clock cycles after the edge at which `in_valid` was sampled high, and the matching result is on `out_root` in that cycle.
- R3: An operand can be accepted on every cycle. Back-to-back operands come out in issue order on consecutive cycles, and none is lost.
- R4: A cycle with `in_valid` low produces a cycle with `out_valid` low 6 cycles later. No result appears without an operand.
- R5: An operand of 0 gives a result of 0.
- R6: An operand of 2^64−1 gives 0xFFFFFFFFF, which is integer part 4294967295 and fraction 15/16.
- R7: When `rst_n` is sampled low at a rising edge, every stage's valid flag clears. `out_valid` is low after that edge, and operands in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the stage valid flags |
| in_valid | input | 1 | Operand on `in_data` is to be processed this cycle |
| in_data | input | 64 | Unsigned integer operand |
| out_valid | output | 1 | `out_root` holds a result this cycle |
| out_root | output | 36 | Square root in unsigned 32.4 fixed point |

## Verification
Random 64-bit operands exercise R1 across the full range. Perfect squares and their immediate neighbours separate true truncation from an off-by-one in the last fraction bit, because k² must give an exact 16k while k²−1 must fall just below it. The operands 0, 1 and all-ones check the empty-root, smallest-root and widest-remainder extremes. Back-to-back bursts interleaved with idle gaps, together with a reset while operands are in flight, check that results keep their order and latency, that gaps stay gaps, and that dropped operands never appear.

// File: rtl/sqrt_pkg.sv
// Package: sqrt_pkg
// Shared constants and helpers for the pipelined square root.
// Assumes nothing beyond IEEE 1800-2017 elaboration-time evaluation.
package sqrt_pkg;

    // Radicand bits consumed per root bit in the digit recurrence.
    localparam int PAIR_W = 2;

    // Integer ceiling of a / b, used to size stage slices.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/sqrt_step.sv
// Module: sqrt_step
// One restoring digit step of the integer square root, purely combinational.
// It brings down one radicand bit pair, tries to subtract (4*root + 1), and
// appends the resulting root bit.
// Assumes rem_i <= 2*root_i on entry, so REM_W = ROOT_W + 3 never overflows.
module sqrt_step #(
    parameter int ROOT_W = 36,
    parameter int REM_W  = ROOT_W + 3
) (
    input  logic [REM_W-1:0]  rem_i,
    input  logic [ROOT_W-1:0] root_i,
    input  logic [1:0]        pair_i,
    output logic [REM_W-1:0]  rem_o,
    output logic [ROOT_W-1:0] root_o
);
    localparam int EXT_W = REM_W - ROOT_W - 2;

    logic [REM_W-1:0] trial;
    logic [REM_W-1:0] subtrahend;
    logic             fits;

    // Forms the trial remainder and subtrahend, then keeps or restores the remainder.
    always_comb begin
        trial      = {rem_i[REM_W-3:0], pair_i};
        subtrahend = {{EXT_W{1'b0}}, root_i, 2'b01};
        fits       = (trial >= subtrahend);
        rem_o      = fits ? (trial - subtrahend) : trial;
        root_o     = {root_i[ROOT_W-2:0], fits};
    end

endmodule

// File: rtl/sqrt_stage.sv
// Module: sqrt_stage
// One pipeline stage. It chains BITS digit steps combinationally and
// registers the partial root, the partial remainder, the padded radicand and
// the valid flag.
// Assumes stage STAGE_IDX consumes radicand pairs STAGE_IDX*BITS up to
// STAGE_IDX*BITS + BITS - 1, counted from the MSB. The data registers are not
// reset. Only the valid flag is reset.
module sqrt_stage
    import sqrt_pkg::*;
#(
    parameter int RAD_W     = 72,
    parameter int ROOT_W    = 36,
    parameter int REM_W     = ROOT_W + 3,
    parameter int BITS      = 6,
    parameter int STAGE_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [RAD_W-1:0]  rad_i,
    input  logic [REM_W-1:0]  rem_i,
    input  logic [ROOT_W-1:0] root_i,
    output logic              valid_q,
    output logic [RAD_W-1:0]  rad_q,
    output logic [REM_W-1:0]  rem_q,
    output logic [ROOT_W-1:0] root_q
);
    localparam int FIRST_PAIR = STAGE_IDX * BITS;

    logic [REM_W-1:0]  rem_c  [0:BITS];
    logic [ROOT_W-1:0] root_c [0:BITS];

    assign rem_c[0]  = rem_i;
    assign root_c[0] = root_i;

    // Unrolls the recurrence over this stage's share of root bits.
    for (genvar j = 0; j < BITS; j++) begin : g_step
        localparam int TOP = RAD_W - 1 - PAIR_W * (FIRST_PAIR + j);
        sqrt_step #(
            .ROOT_W (ROOT_W),
            .REM_W  (REM_W)
        ) u_step (
            .rem_i  (rem_c[j]),
            .root_i (root_c[j]),
            .pair_i (rad_i[TOP -: PAIR_W]),
            .rem_o  (rem_c[j+1]),
            .root_o (root_c[j+1])
        );
    end

    // Carries the valid flag forward and clears it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_i;
    end

    // Captures this stage's partial results and the radicand, without reset.
    always_ff @(posedge clk) begin
        rad_q  <= rad_i;
        rem_q  <= rem_c[BITS];
        root_q <= root_c[BITS];
    end

    // R2 / R4: a valid slot advances one stage per cycle, and so does a bubble.
    assert_valid_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_q);
    assert_bubble_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_q);

    // R7: reset sampled low leaves the stage empty.
    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> !valid_q);

    // R1: the restoring invariant holds: the remainder never exceeds twice the root.
    assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ({1'b0, rem_q} <= {2'b00, root_q, 1'b0}));

endmodule

// File: rtl/sqrt_pipe.sv
// Module: sqrt_pipe
// Top level of the pipelined 64-bit square root with a 32.4 fixed-point result.
// It pads the operand with 2*FRAC_W zero bits and runs the unrolled integer
// root over STAGES registered stages, one operand per cycle.
// Assumes (IN_W/2 + FRAC_W) is divisible by STAGES. There is no backpressure.
module sqrt_pipe
    import sqrt_pkg::*;
#(
    parameter int IN_W   = 64,
    parameter int FRAC_W = 4,
    parameter int STAGES = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [IN_W-1:0]             in_data,
    output logic                        out_valid,
    output logic [IN_W/2+FRAC_W-1:0]    out_root
);
    localparam int PAD_W  = 2 * FRAC_W;
    localparam int RAD_W  = IN_W + PAD_W;
    localparam int ROOT_W = RAD_W / 2;
    localparam int REM_W  = ROOT_W + 3;
    localparam int BITS   = ceil_div(ROOT_W, STAGES);
    localparam int SQ_W   = 2 * ROOT_W + 2;

    logic              v_s    [0:STAGES];
    logic [RAD_W-1:0]  rad_s  [0:STAGES];
    logic [REM_W-1:0]  rem_s  [0:STAGES];
    logic [ROOT_W-1:0] root_s [0:STAGES];

    // Feeds stage 0 with the zero-padded radicand and an empty root.
    always_comb begin
        v_s[0]    = in_valid;
        rad_s[0]  = {in_data, {PAD_W{1'b0}}};
        rem_s[0]  = '0;
        root_s[0] = '0;
    end

    // Builds the chain of registered stages.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        sqrt_stage #(
            .RAD_W     (RAD_W),
            .ROOT_W    (ROOT_W),
            .REM_W     (REM_W),
            .BITS      (BITS),
            .STAGE_IDX (s)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (v_s[s]),
            .rad_i   (rad_s[s]),
            .rem_i   (rem_s[s]),
            .root_i  (root_s[s]),
            .valid_q (v_s[s+1]),
            .rad_q   (rad_s[s+1]),
            .rem_q   (rem_s[s+1]),
            .root_q  (root_s[s+1])
        );
    end

    assign out_valid = v_s[STAGES];
    assign out_root  = root_s[STAGES];

    // R1: the root squared, plus the final remainder, rebuilds the padded radicand.
    assert_exact_residual_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (({{(SQ_W-ROOT_W){1'b0}}, out_root} * {{(SQ_W-ROOT_W){1'b0}}, out_root})
                       + {{(SQ_W-REM_W){1'b0}}, rem_s[STAGES]})
                      == {{(SQ_W-RAD_W){1'b0}}, rad_s[STAGES]});

    // R1: the next step of 1/16 would overshoot, so the root is truncated.
    assert_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (({{(SQ_W-ROOT_W){1'b0}}, out_root} + 1'b1)
                       * ({{(SQ_W-ROOT_W){1'b0}}, out_root} + 1'b1))
                      > {{(SQ_W-RAD_W){1'b0}}, rad_s[STAGES]});

endmodule

// File: tb/tb_sqrt_pipe.sv
`timescale 1ns/1ps
module tb_sqrt_pipe;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [35:0] out_root;

    always #2 clk = ~clk;

    sqrt_pipe dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .out_valid (out_valid), .out_root (out_root)
    );

    typedef struct {
        logic [63:0] x;
        logic [35:0] exp;
        int          issue;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference: builds the 36-bit root by setting bits while the square stays within x*256.
    function automatic logic [35:0] ref_sqrt(input logic [63:0] x);
        logic [71:0] n;
        logic [35:0] r;
        logic [35:0] t;
        n = {x, 8'h00};
        r = '0;
        for (int b = 35; b >= 0; b--) begin
            t = r | (36'd1 << b);
            if (({36'd0, t} * {36'd0, t}) <= n) r = t;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: presents one operand for one cycle and records the expected result.
    task automatic issue(input logic [63:0] x, input string tag);
        item_t it;
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = x;
        it.x = x; it.exp = ref_sqrt(x); it.issue = cyc; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_data  = $urandom();
        end
    endtask

    // Monitor: pops and compares each result as it appears.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R4 spurious out_valid", 64'(out_root), 64'd0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(out_root == it.exp, it.tag, 64'(out_root), 64'(it.exp));
                    check((cyc - it.issue) == LAT, "R2 latency", 64'(cyc - it.issue), 64'(LAT));
                end
            end else if (q.size() != 0 && (cyc - q[0].issue) > LAT) begin
                check(1'b0, "R3 result lost", 64'(cyc - q[0].issue), 64'(LAT));
                void'(q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 reset state", 64'(out_valid), 64'd0);
        #1 rst_n = 1'b1;

        // R5, R6 and single-bit corners.
        issue(64'd0, "R5 zero");
        issue(64'd1, "R1 one");
        issue(64'hFFFF_FFFF_FFFF_FFFF, "R6 all ones");
        idle(8);
        // R4: operands separated by idle gaps.
        issue(64'd2, "R4 gap operand");
        idle(1);
        issue(64'd3, "R4 gap operand");
        idle(3);
        issue(64'd1000000, "R4 gap operand");
        idle(8);
        // R1: perfect squares and their neighbours, issued back to back (R3).
        for (int i = 0; i < 12; i++) begin
            logic [31:0] k;
            logic [63:0] sq;
            k  = (i < 4) ? 32'(i + 2) : ((i < 8) ? $urandom() : 32'hFFFF_FFFF - 32'(i - 8));
            sq = {32'd0, k} * {32'd0, k};
            issue(sq,         "R1 square");
            issue(sq - 64'd1, "R1 square minus one");
            issue(sq + 64'd1, "R3 back-to-back square plus one");
        end
        idle(8);
        // R1 and R3: random operands, back to back.
        for (int i = 0; i < 200; i++) begin
            issue({$urandom(), $urandom()} >> ($urandom() % 64), "R1 random");
        end
        idle(8);
        // R7: reset while operands are in flight.
        issue(64'd12345, "R7 dropped");
        issue(64'd67890, "R7 dropped");
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        q.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R7 flush", 64'(out_valid), 64'd0);
        #1 rst_n = 1'b1;
        idle(8);
        issue(64'd144, "R7 after reset");
        idle(10);
        check(q.size() == 0, "R3 all delivered", 64'(q.size()), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule